// File: doc/BRIEF.md
# Six-Pin GPIO Port with Clock-Out Override

This block is a small bidirectional port of six general-purpose pins driven from a simple register bus. Software sets the level each pin drives through a data register and chooses, pin by pin, whether the output driver is on through a direction register. The block hands the pad ring three vectors: the level to drive, the driver enable, and the level received. Received levels pass through a two-flop synchronizer before software can see them.

The top bit of the direction register is a clock-output switch. While it is set, pin 2 leaves normal I/O duty and drives the block's own clock out, with its driver forced on whatever its direction bit says. Reset turns every driver off and clears the switch. It leaves the data latch alone, so software can preload levels before it turns drivers on. Writing data before turning a direction bit on is the expected order, so that no glitch appears on the pin.

Top module: `gpio6_clkout_port`

## Requirements
- R1: Direction bit i (register at address 0x06, bits 5..0) set to 1 drives pad_oe[i] high on the cycle after the write. A 0 leaves the pin as an input with pad_oe[i] low.
- R2: While rst_n is low at a rising edge, all direction bits and the clock-output switch clear. After reset, pad_oe is 0 and the direction register reads 0x00.
- R3: Reset does not change the data latch. pad_out (apart from pin 2 while clock-out is on) keeps the value last written before reset.
- R4: A write with bus_wr high at address 0x02 loads bus_wdata[5:0] into the data latch at the rising edge. pad_out[i] then equals latch bit i.
- R5: The direction register reads as {switch, 0, dir[5:0]}. Bit 7 is the read/write clock-output switch, and bit 6 always reads 0 even after a 1 is written to it.
- R6: While the switch is 1, pad_oe[2] is 1 and pad_out[2] follows clk, whatever dir[2] and latch bit 2 hold. Other pins are unaffected.
- R7: A read at address 0x02 returns, for each pin i, latch bit i if dir[i] is 1 and the synchronized pin level if dir[i] is 0. Bits 7..6 read 0, and writes to them are ignored.
- R8: A change on pad_in that is stable before rising edge k shows in a data read only after edge k+1, and not after edge k alone.
- R9: Reads of any address other than 0x02 and 0x06 return 0x00. Writes there change neither register nor any pin output.
- R10: Reads are combinational from bus_addr. Register writes take effect only on the rising edge while bus_wr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the source for the pin 2 clock output |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data from the addressed register |
| pad_in | input | 6 | Levels received from the pads |
| pad_out | output | 6 | Levels to drive onto the pads |
| pad_oe | output | 6 | Output driver enables, one per pad |

## Verification
The bound checker watches, on every cycle, the link between the bus and the pads. After each data write the non-clock pins show the written bits. After each direction write their driver enables match the written bits. Setting the switch always forces pin 2's driver on. Bit 6 and the unused data bits never read back as 1, and drivers come out of reset off. Some behaviour appears only in the bench's scenarios: the latch surviving a reset, the two-edge synchronizer delay, pin 2 actually toggling with the clock at both phases, and the per-pin mix of latch and pin levels in data reads.

// File: rtl/gpio6_pkg.sv
// Shared constants for the six-pin GPIO port.
// Assumes an 8-bit register bus; the pin count must leave room for the
// reserved bit and the clock-output switch in the direction register.
package gpio6_pkg;
    localparam int BUS_W         = 8;
    localparam int ADDR_W        = 8;
    localparam int PIN_COUNT     = 6;
    localparam int CLKOUT_PIN    = 2;
    localparam int SWITCH_BIT    = 7;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 8'h02;
    localparam logic [ADDR_W-1:0] ADDR_DIR  = 8'h06;

    // Which register a bus address selects.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/gpio6_sync.sv
// Multi-stage synchronizer for the pad input levels.
// Assumes pad inputs are asynchronous to clk; STAGES must be at least 2.
// Resets to all zeros so reads are defined right after reset.
module gpio6_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw pad level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Later stages: let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio6_regs.sv
// Register file of the GPIO port: data latch, direction bits and the
// clock-output switch, plus the combinational read multiplexer.
// Assumes a single-cycle write strobe sampled on the rising edge. The data
// latch has no reset on purpose: reset must leave the port data untouched.
module gpio6_regs
    import gpio6_pkg::*;
#(
    parameter int               NPINS     = PIN_COUNT,
    parameter int               DW        = BUS_W,
    parameter int               AW        = ADDR_W,
    parameter int               SW_BIT    = SWITCH_BIT,
    parameter logic [AW-1:0]    DATA_ADDR = ADDR_DATA,
    parameter logic [AW-1:0]    DIR_ADDR  = ADDR_DIR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic [NPINS-1:0] pin_sync,
    output logic [DW-1:0]    bus_rdata,
    output logic [NPINS-1:0] latch_q,
    output logic [NPINS-1:0] dir_q,
    output logic             clken_q
);
    localparam int PAD_W = DW - NPINS;

    reg_sel_e         sel;
    logic             wr_data;
    logic             wr_dir;
    logic [NPINS-1:0] data_view;

    // Decode the bus address into a register select.
    always_comb begin
        if (bus_addr == DATA_ADDR)     sel = SEL_DATA;
        else if (bus_addr == DIR_ADDR) sel = SEL_DIR;
        else                           sel = SEL_NONE;
    end

    assign wr_data = bus_wr && (sel == SEL_DATA);
    assign wr_dir  = bus_wr && (sel == SEL_DIR);

    // Data latch: loaded by bus writes only, untouched by reset.
    always_ff @(posedge clk) begin
        if (wr_data) latch_q <= bus_wdata[NPINS-1:0];
    end

    // Direction bits and clock-output switch: cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            clken_q <= 1'b0;
        end else if (wr_dir) begin
            dir_q   <= bus_wdata[NPINS-1:0];
            clken_q <= bus_wdata[SW_BIT];
        end
    end

    // Per-pin read view: latch for outputs, synchronized level for inputs.
    genvar p;
    generate
        for (p = 0; p < NPINS; p++) begin : g_view
            assign data_view[p] = dir_q[p] ? latch_q[p] : pin_sync[p];
        end
    endgenerate

    // Read multiplexer; reserved and unused bits return zero.
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_DATA: bus_rdata = {{PAD_W{1'b0}}, data_view};
            SEL_DIR: begin
                bus_rdata[NPINS-1:0] = dir_q;
                bus_rdata[SW_BIT]    = clken_q;
            end
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio6_pinmux.sv
// Pad output multiplexer: drives latch bits and direction enables to the
// pads, and replaces one chosen pin with the block clock when the switch
// is on. Assumes CLK_PIN is a valid pin index.
module gpio6_pinmux #(
    parameter int NPINS   = 6,
    parameter int CLK_PIN = 2
) (
    input  logic             clk,
    input  logic             clken,
    input  logic [NPINS-1:0] latch,
    input  logic [NPINS-1:0] dir,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    genvar p;
    generate
        for (p = 0; p < NPINS; p++) begin : g_pin
            if (p == CLK_PIN) begin : g_clkpin
                // Clock-capable pin: the switch overrides level and enable.
                always_comb begin
                    pad_out[p] = clken ? clk  : latch[p];
                    pad_oe[p]  = clken ? 1'b1 : dir[p];
                end
            end else begin : g_plain
                // Ordinary pin: latch level, direction enable.
                always_comb begin
                    pad_out[p] = latch[p];
                    pad_oe[p]  = dir[p];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio6_clkout_port.sv
// Top of the six-pin GPIO port with a clock-output override on pin 2.
// Assumes synchronous active-low reset and an 8-bit register bus. Pad
// inputs go through a synchronizer before software can read them.
module gpio6_clkout_port
    import gpio6_pkg::*;
#(
    parameter int               NPINS       = PIN_COUNT,
    parameter int               CLK_PIN     = CLKOUT_PIN,
    parameter int               SYNC_STAGES = 2,
    parameter int               DW          = BUS_W,
    parameter int               AW          = ADDR_W,
    parameter int               SW_BIT      = SWITCH_BIT,
    parameter logic [AW-1:0]    DATA_ADDR   = ADDR_DATA,
    parameter logic [AW-1:0]    DIR_ADDR    = ADDR_DIR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] dir_q;
    logic             clken_q;

    gpio6_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio6_regs #(
        .NPINS     (NPINS),
        .DW        (DW),
        .AW        (AW),
        .SW_BIT    (SW_BIT),
        .DATA_ADDR (DATA_ADDR),
        .DIR_ADDR  (DIR_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .clken_q   (clken_q)
    );

    gpio6_pinmux #(
        .NPINS   (NPINS),
        .CLK_PIN (CLK_PIN)
    ) u_pinmux (
        .clk     (clk),
        .clken   (clken_q),
        .latch   (latch_q),
        .dir     (dir_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );
endmodule

// File: rtl/gpio6_clkout_port_chk.sv
// Checker for the GPIO port, bound to every instance of the top module.
// Relates bus writes to pad outputs and read data over time.
module gpio6_clkout_port_chk #(
    parameter int            NPINS     = 6,
    parameter int            CLK_PIN   = 2,
    parameter int            DW        = 8,
    parameter int            AW        = 8,
    parameter int            SW_BIT    = 7,
    parameter logic [AW-1:0] DATA_ADDR = 8'h02,
    parameter logic [AW-1:0] DIR_ADDR  = 8'h06
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_wr,
    input logic [DW-1:0]    bus_wdata,
    input logic [DW-1:0]    bus_rdata,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe
);
    localparam logic [NPINS-1:0] PLAIN = ~(NPINS'(1) << CLK_PIN);

    // R4: data write shows on the plain pins one edge later.
    a_r4_data_to_pads: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_ADDR) |=>
        ((pad_out & PLAIN) == ($past(bus_wdata[NPINS-1:0]) & PLAIN)));

    // R1: direction write sets the plain pins' driver enables.
    a_r1_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DIR_ADDR) |=>
        ((pad_oe & PLAIN) == ($past(bus_wdata[NPINS-1:0]) & PLAIN)));

    // R6: turning the switch on forces the clock pin's driver on.
    a_r6_switch_forces_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DIR_ADDR && bus_wdata[SW_BIT]) |=> pad_oe[CLK_PIN]);

    // R5: bit 6 of the direction register never reads as 1.
    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DIR_ADDR) |-> !bus_rdata[SW_BIT-1]);

    // R7: unused high bits of the data register read as 0.
    a_r7_data_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DATA_ADDR) |-> (bus_rdata[DW-1:NPINS] == '0));

    // R2: drivers are all off right after reset is released.
    a_r2_oe_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0));

    // R9: unmapped addresses read zero.
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != DATA_ADDR && bus_addr != DIR_ADDR) |-> (bus_rdata == '0));
endmodule

bind gpio6_clkout_port gpio6_clkout_port_chk #(
    .NPINS     (NPINS),
    .CLK_PIN   (CLK_PIN),
    .DW        (DW),
    .AW        (AW),
    .SW_BIT    (SW_BIT),
    .DATA_ADDR (DATA_ADDR),
    .DIR_ADDR  (DIR_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio6_clkout_port_bench.sv
`timescale 1ns/1ps
module gpio6_clkout_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [5:0] pad_in = 6'h2A;
    logic [5:0] pad_out;
    logic [5:0] pad_oe;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    gpio6_clkout_port u_gpio6_clkout_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    // Vector: write addr, write data, expected read of same addr, oe, out.
    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] wdata;
        logic [7:0] rd;
        logic [5:0] oe;
        logic [5:0] out;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{8'h02, 8'h15, 8'h2A, 6'h00, 6'h15},  // R4 R7 inputs read pins
        '{8'h06, 8'h3F, 8'h3F, 6'h3F, 6'h15},  // R1 R5 all outputs
        '{8'h02, 8'hEA, 8'h2A, 6'h3F, 6'h2A},  // R7 high bits ignored
        '{8'h06, 8'h4F, 8'h0F, 6'h0F, 6'h2A},  // R5 bit 6 reads 0
        '{8'h02, 8'h05, 8'h25, 6'h0F, 6'h05},  // R7 mixed latch and pins
        '{8'h03, 8'hFF, 8'h00, 6'h0F, 6'h05},  // R9 unmapped write
        '{8'h06, 8'h00, 8'h00, 6'h00, 6'h05}   // R1 back to inputs
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        bus_addr = 8'h06; #1;
        check("R2 dir reads 0", bus_rdata, 8'h00);
        check("R2 oe off", {2'b0, pad_oe}, 8'h00);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VECS[i].addr, VECS[i].wdata);
            check("R10 table read", bus_rdata, VECS[i].rd);
            check("R1 table oe", {2'b0, pad_oe}, {2'b0, VECS[i].oe});
            check("R4 table out", {2'b0, pad_out}, {2'b0, VECS[i].out});
        end

        // R3: latch survives reset
        bus_write(8'h02, 8'h33);
        bus_write(8'h06, 8'h3F);
        do_reset();
        check("R3 latch kept", {2'b0, pad_out}, 8'h33);
        check("R2 oe cleared", {2'b0, pad_oe}, 8'h00);
        bus_addr = 8'h06; #1;
        check("R2 dir cleared", bus_rdata, 8'h00);

        // R6: clock-out switch, dir[2]=0 and latch bit 2 = 0
        bus_write(8'h02, 8'h00);
        bus_write(8'h06, 8'h80);
        check("R5 switch readback", bus_rdata, 8'h80);
        check("R6 oe forced", {2'b0, pad_oe}, 8'h04);
        @(posedge clk); #1;
        check("R6 pin high phase", {7'b0, pad_out[2]}, 8'h01);
        @(negedge clk); #1;
        check("R6 pin low phase", {7'b0, pad_out[2]}, 8'h00);
        check("R6 other pins", {2'b0, pad_out & 6'h3B}, 8'h00);
        bus_write(8'h02, 8'h04);
        check("R6 latch ignored", {7'b0, pad_out[2]}, 8'h00);
        bus_write(8'h06, 8'h00);
        check("R6 switch off restores", {2'b0, pad_out}, 8'h04);
        check("R6 oe off", {2'b0, pad_oe}, 8'h00);

        // R2: reset clears the switch
        bus_write(8'h06, 8'h80);
        do_reset();
        check("R2 switch cleared", {2'b0, pad_oe}, 8'h00);

        // R8: two-edge synchronizer delay, all pins inputs
        bus_addr = 8'h02;
        @(negedge clk); pad_in = 6'h15;
        @(posedge clk); #1;
        check("R8 after one edge", bus_rdata, 8'h2A);
        @(posedge clk); #1;
        check("R8 after two edges", bus_rdata, 8'h15);

        // R10: strobe low means no write
        @(negedge clk); bus_addr = 8'h06; bus_wdata = 8'h3F; bus_wr = 1'b0;
        @(negedge clk); #1;
        check("R10 no strobe no write", bus_rdata, 8'h00);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule